// File: doc/BRIEF.md
# Vector Load/Store Element Sequencer

This block turns one vector memory instruction into a stream of per-element memory requests. On a start pulse it captures a base address, a stride-or-offset value, a packed vector of per-element index values, the vector length, an addressing mode, a fail-first enable and the operation and element size codes. It then issues one request per accepted handshake: an address and the element number. Elements go in ascending order from element 0.

For each accepted request, a memory-side stub returns a fault indication in the same cycle. When the sequence ends, the block gives a one-cycle done pulse. The final vector length, an exception flag and an illegal-configuration flag are presented with that pulse and held until the next completion.

Fail-first mode treats element 0 as an ordinary access. A fault on a later element is speculative: it raises no exception and only shortens the vector length. Fail-first never uses indexed addressing. A configuration input can cap every fail-first operation at one element. This is the minimal form, and it does not allow probing of memory.

Top module: `vls_seq`

## Requirements
- R1: A start pulse is accepted only while no request is pending (req_valid low). While a sequence is running, start is ignored, and the running sequence keeps its captured inputs.
- R2: Mode code 0 (unit stride) places element i at base_addr + i * 2^op_size bytes. The size codes 0..3 stand for 1, 2, 4 and 8 bytes. Mode code 3 behaves as code 0.
- R3: Mode code 1 (element strided) places element i at base_addr + i * stride_val, modulo 2^AW.
- R4: Mode code 2 (indexed) with fail-first off places element i at idx_vec[i*AW +: AW] + stride_val.
- R5: Requests are offered on req_valid with element numbers 0, 1, 2, … in order. One element advances per cycle in which req_ready is high. Address and element stay stable while req_ready is low.
- R6: After a sequence with no fault, done pulses for exactly one cycle, in the cycle after the final handshake. At that point vl_out equals the vector length, exc_raise is 0 and req_valid is low.
- R7: With fail-first off, a fault on any element ends the sequence. No further requests are issued, exc_raise is 1 and vl_out keeps the full vector length.
- R8: With fail-first on, a fault on element 0 ends the sequence with exc_raise set to 1.
- R9: With fail-first on, a fault on element i ≥ 1 ends the sequence with exc_raise 0 and vl_out equal to i.
- R10: With fail-first on, mode code 2 selects element-strided addressing, as R3 describes.
- R11: When cfg_ff_one is high and fail-first is on, a nonzero vector length is cut to 1, so exactly one request is issued. cfg_ff_one has no effect when fail-first is off.
- R12: When elw_size < op_size, no request is issued. done pulses in the cycle after start, with illegal 1, exc_raise 0 and vl_out equal to vl_in.
- R13: With a legal size pair and vl_in of 0, no request is issued. done pulses in the cycle after start, with vl_out 0 and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new vector operation |
| base_addr | input | AW | Base address |
| stride_val | input | AW | Stride (mode 1) or index offset (mode 2) |
| idx_vec | input | MAXVL*AW | Packed per-element index values, element i at bits i*AW |
| vl_in | input | VLW | Requested vector length, 0..MAXVL |
| mode_sel | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| ffirst | input | 1 | Fail-first enable |
| cfg_ff_one | input | 1 | Cap fail-first operations at one element |
| op_size | input | 2 | Access size code (2^code bytes) |
| elw_size | input | 2 | Memory-side element width code |
| req_valid | output | 1 | Element request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | AW | Element address |
| req_elem | output | EW | Element number |
| rsp_fault | input | 1 | Fault for the element accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Final vector length |
| exc_raise | output | 1 | Exception to be raised |
| illegal | output | 1 | Size combination was illegal |

## Verification
The assertions check several properties on every cycle. Requests stay stable under back-pressure and advance one element per handshake. Completion is a single-cycle pulse. A fault produces the right outcome: an exception for element 0 or for any element when fail-first is off, and a quiet shortening to the faulting element's number otherwise. Illegal sizes and zero-length operations finish in one cycle with no request. Only the bench scenarios can show that the addresses are correct in each mode and size, that fail-first redirects indexed mode to strided, that the one-element cap applies, and that a start during a running sequence leaves the sequence unchanged.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // memory-side element narrower than the access: undefined, flagged
    function automatic logic size_illegal(input logic [1:0] op_sz,
                                          input logic [1:0] elw_sz);
        return elw_sz < op_sz;
    endfunction

    // fail-first never indexes; reserved code falls back to unit stride
    function automatic amode_e resolve_mode(input logic [1:0] m,
                                            input logic       ff);
        amode_e r;
        case (m)
            2'd1:    r = AM_STRIDE;
            2'd2:    r = ff ? AM_STRIDE : AM_INDEX;
            default: r = AM_UNIT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int AW    = 32,
    parameter int MAXVL = 16,
    parameter int EW    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  advance,
    input  logic [AW-1:0]         base,
    input  logic [AW-1:0]         stride,
    input  logic [MAXVL*AW-1:0]   idx_vec,
    input  logic [1:0]            op_size,
    input  amode_e                mode,
    input  logic [EW-1:0]         elem,
    output logic [AW-1:0]         addr
);
    logic [AW-1:0]       cur_q;
    logic [AW-1:0]       step_q;
    logic [AW-1:0]       ofs_q;
    amode_e              mode_q;
    logic [MAXVL*AW-1:0] idx_q;
    logic [AW-1:0]       idx_arr [MAXVL];

    generate
        for (genvar g = 0; g < MAXVL; g++) begin : g_idx
            assign idx_arr[g] = idx_q[g*AW +: AW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            step_q <= '0;
            ofs_q  <= '0;
            mode_q <= AM_UNIT;
            idx_q  <= '0;
        end else if (load) begin
            cur_q  <= base;
            step_q <= (mode == AM_STRIDE) ? stride : (AW'(1) << op_size);
            ofs_q  <= stride;
            mode_q <= mode;
            idx_q  <= idx_vec;
        end else if (advance) begin
            cur_q  <= cur_q + step_q;
        end
    end

    assign addr = (mode_q == AM_INDEX) ? idx_arr[elem] + ofs_q : cur_q;

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int EW  = 4,
    parameter int VLW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  logic           ffirst,
    input  logic           cfg_ff_one,
    input  logic           illegal_cfg,
    input  logic           req_ready,
    input  logic           rsp_fault,
    output logic           busy,
    output logic [EW-1:0]  elem,
    output logic           load,
    output logic           advance,
    output logic           ff_active,
    output logic           done,
    output logic [VLW-1:0] vl_out,
    output logic           exc_raise,
    output logic           illegal
);
    state_e         state_q;
    logic [EW-1:0]  elem_q;
    logic [VLW-1:0] vl_q;
    logic           ff_q;
    logic [VLW-1:0] vl_eff;
    logic           last;
    logic           hs;

    assign busy      = (state_q == ST_RUN);
    assign elem      = elem_q;
    assign ff_active = ff_q;
    assign load      = (state_q == ST_IDLE) && start;
    assign vl_eff    = (ffirst && cfg_ff_one && vl_in != '0) ? VLW'(1) : vl_in;
    assign last      = (VLW'(elem_q) + VLW'(1)) == vl_q;
    assign hs        = busy && req_ready;
    assign advance   = hs && !rsp_fault && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            vl_q      <= '0;
            ff_q      <= 1'b0;
            done      <= 1'b0;
            vl_out    <= '0;
            exc_raise <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ff_q   <= ffirst;
                        vl_q   <= vl_eff;
                        elem_q <= '0;
                        if (illegal_cfg) begin
                            done      <= 1'b1;
                            illegal   <= 1'b1;
                            exc_raise <= 1'b0;
                            vl_out    <= vl_in;
                        end else if (vl_in == '0) begin
                            done      <= 1'b1;
                            illegal   <= 1'b0;
                            exc_raise <= 1'b0;
                            vl_out    <= '0;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (hs) begin
                        if (rsp_fault) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                            illegal <= 1'b0;
                            if (ff_q && elem_q != '0) begin
                                exc_raise <= 1'b0;
                                vl_out    <= VLW'(elem_q);
                            end else begin
                                exc_raise <= 1'b1;
                                vl_out    <= vl_q;
                            end
                        end else if (last) begin
                            state_q   <= ST_IDLE;
                            done      <= 1'b1;
                            illegal   <= 1'b0;
                            exc_raise <= 1'b0;
                            vl_out    <= vl_q;
                        end else begin
                            elem_q <= elem_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vls_seq.sv
module vls_seq
    import vls_pkg::*;
#(
    parameter int AW    = 32,
    parameter int MAXVL = 16,
    localparam int EW   = $clog2(MAXVL),
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [AW-1:0]       base_addr,
    input  logic [AW-1:0]       stride_val,
    input  logic [MAXVL*AW-1:0] idx_vec,
    input  logic [VLW-1:0]      vl_in,
    input  logic [1:0]          mode_sel,
    input  logic                ffirst,
    input  logic                cfg_ff_one,
    input  logic [1:0]          op_size,
    input  logic [1:0]          elw_size,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [AW-1:0]       req_addr,
    output logic [EW-1:0]       req_elem,
    input  logic                rsp_fault,
    output logic                done,
    output logic [VLW-1:0]      vl_out,
    output logic                exc_raise,
    output logic                illegal
);
    amode_e mode_eff;
    logic   illegal_cfg;
    logic   load;
    logic   advance;
    logic   ff_active;

    assign mode_eff    = resolve_mode(mode_sel, ffirst);
    assign illegal_cfg = size_illegal(op_size, elw_size);

    vls_ctrl #(.EW(EW), .VLW(VLW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vl_in       (vl_in),
        .ffirst      (ffirst),
        .cfg_ff_one  (cfg_ff_one),
        .illegal_cfg (illegal_cfg),
        .req_ready   (req_ready),
        .rsp_fault   (rsp_fault),
        .busy        (req_valid),
        .elem        (req_elem),
        .load        (load),
        .advance     (advance),
        .ff_active   (ff_active),
        .done        (done),
        .vl_out      (vl_out),
        .exc_raise   (exc_raise),
        .illegal     (illegal)
    );

    vls_addr_gen #(.AW(AW), .MAXVL(MAXVL), .EW(EW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .base    (base_addr),
        .stride  (stride_val),
        .idx_vec (idx_vec),
        .op_size (op_size),
        .mode    (mode_eff),
        .elem    (req_elem),
        .addr    (req_addr)
    );

endmodule

// File: rtl/vls_chk.sv
module vls_chk #(
    parameter int AW  = 32,
    parameter int EW  = 4,
    parameter int VLW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [VLW-1:0] vl_in,
    input logic           illegal_cfg,
    input logic           ff_act,
    input logic           req_valid,
    input logic           req_ready,
    input logic [AW-1:0]  req_addr,
    input logic [EW-1:0]  req_elem,
    input logic           rsp_fault,
    input logic           done,
    input logic [VLW-1:0] vl_out,
    input logic           exc_raise,
    input logic           illegal
);
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_elem)); // R5

    AST_NEXT_ELEM: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !rsp_fault |=> done || (req_valid && req_elem == $past(req_elem) + EW'(1))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid); // R6

    AST_PLAIN_FAULT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && rsp_fault && !ff_act |=> done && exc_raise && !req_valid); // R7

    AST_FIRST_FAULT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && rsp_fault && req_elem == '0 |=> done && exc_raise); // R8

    AST_QUIET_TRUNC: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && rsp_fault && ff_act && req_elem != '0
        |=> done && !exc_raise && vl_out == VLW'($past(req_elem))); // R9

    AST_ILLEGAL_STOP: assert property (@(posedge clk) disable iff (rst)
        start && !req_valid && illegal_cfg |=> done && illegal && !req_valid); // R12

    AST_ZERO_VL: assert property (@(posedge clk) disable iff (rst)
        start && !req_valid && !illegal_cfg && vl_in == '0 |=> done && vl_out == '0 && !req_valid); // R13

endmodule

bind vls_seq vls_chk #(.AW(AW), .EW(EW), .VLW(VLW)) u_vls_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .vl_in       (vl_in),
    .illegal_cfg (illegal_cfg),
    .ff_act      (ff_active),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_elem    (req_elem),
    .rsp_fault   (rsp_fault),
    .done        (done),
    .vl_out      (vl_out),
    .exc_raise   (exc_raise),
    .illegal     (illegal)
);

// File: tb/test_vls_seq.sv
`timescale 1ns/1ps
module test_vls_seq;
    localparam int AW    = 32;
    localparam int MAXVL = 16;
    localparam int EW    = 4;
    localparam int VLW   = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [AW-1:0]       base_addr = '0;
    logic [AW-1:0]       stride_val = '0;
    logic [MAXVL*AW-1:0] idx_vec = '0;
    logic [VLW-1:0]      vl_in = '0;
    logic [1:0]          mode_sel = '0;
    logic                ffirst = 1'b0;
    logic                cfg_ff_one = 1'b0;
    logic [1:0]          op_size = '0;
    logic [1:0]          elw_size = '0;
    logic                req_valid;
    logic                req_ready = 1'b1;
    logic [AW-1:0]       req_addr;
    logic [EW-1:0]       req_elem;
    logic                rsp_fault;
    logic                done;
    logic [VLW-1:0]      vl_out;
    logic                exc_raise;
    logic                illegal;
    logic [MAXVL-1:0]    fmask = '0;

    assign rsp_fault = req_valid && fmask[req_elem];

    vls_seq #(.AW(AW), .MAXVL(MAXVL)) i_vls_seq (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .stride_val(stride_val), .idx_vec(idx_vec), .vl_in(vl_in),
        .mode_sel(mode_sel), .ffirst(ffirst), .cfg_ff_one(cfg_ff_one),
        .op_size(op_size), .elw_size(elw_size), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
        .rsp_fault(rsp_fault), .done(done), .vl_out(vl_out),
        .exc_raise(exc_raise), .illegal(illegal)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    bit              started = 1'b0;
    bit              m_busy = 1'b0;
    int              m_elem = 0;
    int              m_vl = 0;
    int              m_mode = 0;
    int              m_op = 0;
    bit              m_ff = 1'b0;
    logic [AW-1:0]   m_base = '0;
    logic [AW-1:0]   m_stride = '0;
    logic [MAXVL*AW-1:0] m_idx = '0;
    bit              m_done = 1'b0;
    int              m_vlout = 0;
    bit              m_exc = 1'b0;
    bit              m_ill = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        m_done  = 1'b0;
        if (rst) begin
            m_busy = 0; m_elem = 0; m_vlout = 0; m_exc = 0; m_ill = 0;
        end else if (!m_busy && start) begin
            m_ff = ffirst;
            m_op = int'(op_size);
            m_base = base_addr; m_stride = stride_val; m_idx = idx_vec;
            m_mode = (mode_sel == 2'd3) ? 0 : int'(mode_sel);
            if (ffirst && m_mode == 2) m_mode = 1;
            m_vl = (ffirst && cfg_ff_one && vl_in != 0) ? 1 : int'(vl_in);
            m_elem = 0;
            if (elw_size < op_size) begin
                m_done = 1; m_ill = 1; m_exc = 0; m_vlout = int'(vl_in);
            end else if (vl_in == 0) begin
                m_done = 1; m_ill = 0; m_exc = 0; m_vlout = 0;
            end else begin
                m_busy = 1;
            end
        end else if (m_busy && req_ready) begin
            if (fmask[m_elem]) begin
                m_busy = 0; m_done = 1; m_ill = 0;
                if (m_ff && m_elem > 0) begin
                    m_exc = 0; m_vlout = m_elem;
                end else begin
                    m_exc = 1; m_vlout = m_vl;
                end
            end else if (m_elem == m_vl - 1) begin
                m_busy = 0; m_done = 1; m_ill = 0; m_exc = 0; m_vlout = m_vl;
            end else begin
                m_elem = m_elem + 1;
            end
        end
    end

    function automatic logic [AW-1:0] exp_addr();
        case (m_mode)
            1:       return m_base + AW'(m_elem) * m_stride;
            2:       return m_idx[m_elem*AW +: AW] + m_stride;
            default: return m_base + AW'(m_elem * (1 << m_op));
        endcase
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check("req_valid", 64'(req_valid), 64'(m_busy));
            check("done", 64'(done), 64'(m_done));
            check("vl_out", 64'(vl_out), 64'(m_vlout));
            check("exc_raise", 64'(exc_raise), 64'(m_exc));
            check("illegal", 64'(illegal), 64'(m_ill));
            if (m_busy) begin
                check("req_elem", 64'(req_elem), 64'(m_elem));
                check("req_addr", 64'(req_addr), 64'(exp_addr()));
            end
        end
        if (rdy_rand) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_ready = lfsr[0] | lfsr[3];
        end else begin
            req_ready = 1'b1;
        end
    end

    task automatic op(input string tag, input logic [AW-1:0] b, input logic [AW-1:0] s,
                      input int vl, input int md, input bit ff, input bit one,
                      input int osz, input int esz, input logic [MAXVL-1:0] fm,
                      input bit restart);
        int wait_n;
        cur_req = tag;
        @(negedge clk);
        base_addr = b; stride_val = s; vl_in = VLW'(vl); mode_sel = 2'(md);
        ffirst = ff; cfg_ff_one = one; op_size = 2'(osz); elw_size = 2'(esz);
        fmask = fm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            @(negedge clk);
            base_addr = 32'hDEAD_0000; stride_val = 32'h40; vl_in = VLW'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (m_busy && wait_n < 300) begin
            @(negedge clk);
            wait_n++;
        end
        if (wait_n >= 300) begin
            n_bad++;
            $display("FAIL %s watchdog: actual busy expected done", tag);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MAXVL; i++)
            idx_vec[i*AW +: AW] = 32'h0004_0000 + AW'(i * i * 24) + AW'((i & 3) << 12);
        // R1: reset state
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 R6: unit stride, every size, fixed and random ready (R5)
        for (int sz = 0; sz < 4; sz++)
            op("R2", 32'h1000_0000 + 32'(sz), 32'h0, 5, 0, 0, 0, sz, 3, '0, 0);
        rdy_rand = 1'b1;
        op("R5", 32'h2000_0100, 32'h0, 9, 0, 0, 0, 2, 3, '0, 0);
        op("R2", 32'h2000_0200, 32'h7, 6, 3, 0, 0, 3, 3, '0, 0);
        // R3: positive and negative strides, full length
        op("R3", 32'h3000_0000, 32'd12, MAXVL, 1, 0, 0, 2, 2, '0, 0);
        op("R3", 32'h3000_1000, 32'hFFFF_FFF0, 4, 1, 0, 0, 0, 0, '0, 0);
        // R4: indexed with offset
        op("R4", 32'h0, 32'd4, 8, 2, 0, 0, 1, 2, '0, 0);
        rdy_rand = 1'b0;
        op("R6", 32'h4000_0000, 32'h0, 1, 0, 0, 0, 0, 0, '0, 0);
        // R7: fault without fail-first
        op("R7", 32'h5000_0000, 32'd8, 8, 1, 0, 0, 3, 3, 16'h0008, 0);
        op("R7", 32'h5000_0000, 32'd8, 8, 0, 0, 0, 3, 3, 16'h0001, 0);
        // R8: fail-first, element 0 faults
        op("R8", 32'h6000_0000, 32'd16, 6, 1, 1, 0, 2, 2, 16'h0001, 0);
        // R9: fail-first quiet truncation
        op("R9", 32'h7000_0000, 32'd16, 10, 1, 1, 0, 2, 2, 16'h0020, 0);
        op("R9", 32'h7000_0000, 32'd16, 10, 0, 1, 0, 2, 2, 16'h0002, 0);
        op("R9", 32'h7000_0000, 32'd16, 10, 1, 1, 0, 2, 2, 16'h0200, 0);
        // R10: fail-first turns indexed into strided
        op("R10", 32'h8000_0000, 32'd20, 5, 2, 1, 0, 1, 1, '0, 0);
        // R11: one-element cap only with fail-first
        op("R11", 32'h9000_0000, 32'd4, 8, 1, 1, 1, 2, 2, '0, 0);
        op("R11", 32'h9000_0000, 32'd4, 8, 1, 1, 1, 2, 2, 16'h0001, 0);
        op("R11", 32'h9000_0000, 32'd4, 3, 1, 0, 1, 2, 2, '0, 0);
        // R12: illegal size pair, and a legal wider element
        op("R12", 32'hA000_0000, 32'd4, 7, 1, 0, 0, 2, 1, '0, 0);
        op("R12", 32'hA000_0000, 32'd4, 7, 2, 1, 0, 3, 0, '0, 0);
        op("R12", 32'hA000_0000, 32'd4, 3, 0, 0, 0, 1, 3, '0, 0);
        // R13: zero length
        op("R13", 32'hB000_0000, 32'd4, 0, 1, 0, 0, 0, 0, '0, 0);
        op("R13", 32'hB000_0000, 32'd4, 0, 1, 1, 1, 0, 0, '0, 0);
        // R1: start while busy is ignored
        rdy_rand = 1'b1;
        op("R1", 32'hC000_0000, 32'd24, 12, 1, 0, 0, 2, 2, '0, 1);
        rdy_rand = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule